// File: doc/BRIEF.md
# Three-Channel Watchdog Timer

This block holds three independent watchdog channels behind a small synchronous register bus. Each channel has a 16-bit countdown value and a reload limit. A shared prescaler divides the system clock into tenth-of-a-second ticks, and every running channel steps its count down by one on each tick. Software starts a channel by writing its limit. It keeps the channel alive by reading the count, which returns the current value and reloads the count from the limit. When the count reaches zero the channel expires and fires its action. Channel 0 raises an interrupt level. Channel 1 pulses a reset output for the processor only. Channel 2 pulses a reset output for the whole system.

A shared mask byte can suppress each channel's action. The counter keeps running while it is masked. The bus has no back-pressure: a read or write strobe is accepted in the cycle it is high. Read data comes back one cycle later, marked by `rd_valid_o`. The address decode uses `addr_i[5:4]` to select a window: channel 0, 1 or 2, or the shared window 3. `addr_i[3:0]` selects the register inside that window.

Top module: `wdog_trio`

## Requirements
- R1: After reset, every channel's count and limit read 1, every status byte reads 0, the mask reads 0, and `irq_o`, `cpu_rst_o` and `sys_rst_o` are low.
- R2: A write to a channel's limit register (offset 0x4 in its window) loads both the limit and the count with `wr_data_i` and sets the running bit (status bit 0). The write also clears the expired bit (status bit 1). A write while running restarts the channel.
- R3: A running channel's count drops by one on each prescaler tick, one tick every `TICK_DIV` clock cycles.
- R4: A read of the count (offset 0x0) returns the value before the read. If the channel is running, the read reloads the count from the limit. A reload and a tick in the same cycle resolve to the reload.
- R5: A read of the limit (offset 0x4) returns the limit and leaves the count unchanged.
- R6: A tick that finds the count at 1 or 0 on a running channel sets the count to 0, clears running and sets expired. After that the count holds at 0, and a read of the count no longer reloads it. The status byte reads `{6'b0, expired, running}`.
- R7: `irq_o` is registered. It goes high on the edge where channel 0 expires with mask bit 0 clear, and stays high while channel 0 is expired. It follows a change of mask bit 0 one cycle later and drops on the edge of a limit write to channel 0.
- R8: On the edge where channel 1 expires with mask bit 1 clear, `cpu_rst_o` goes high for exactly `PULSE_LEN` cycles. If mask bit 1 is set at that edge, there is no pulse, but the channel still counts down and expires.
- R9: On the edge where channel 2 expires with mask bit 2 clear, `sys_rst_o` goes high for exactly `PULSE_LEN` cycles.
- R10: The mask register at 0x30 takes `wr_data_i[2:0]`, one bit per channel, with bit n belonging to channel n. A set bit disables that channel's action.
- R11: The summary register at 0x34 reads the three expired bits in its bits [2:0], with bit n for channel n.
- R12: Writes to a count register or a status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 6 | Byte address of the register |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data (bytes use bits 7:0) |
| rd_data_o | output | 16 | Read data, one cycle after the strobe |
| rd_valid_o | output | 1 | High in the cycle that `rd_data_o` holds a read result |
| irq_o | output | 1 | Interrupt level from channel 0 |
| cpu_rst_o | output | 1 | Processor reset pulse from channel 1 |
| sys_rst_o | output | 1 | System reset pulse from channel 2 |

## Verification
The bench tracks the tick phase from reset release. This lets it place every bus access a known number of cycles after a tick, so it can check expiry and pulse edges to the exact cycle. It targets the keepalive read. A design that reloads before returning would hand back the limit instead of the decremented count. A design that lets a limit read reload, or lets a count read revive an expired channel, would show a nonzero count after expiry. It also covers a masked reset channel that must still expire without pulsing, and an interrupt that must come back when the mask is lifted. It measures the pulse length, which a counter off by one would lengthen or shorten. Stray writes to count and status registers must leave both unchanged.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int NUM_CH   = 3;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 16;
  localparam logic [1:0] SHARED_WIN = 2'd3;
  localparam logic [3:0] OFF_COUNT  = 4'h0;
  localparam logic [3:0] OFF_LIMIT  = 4'h4;
  localparam logic [3:0] OFF_STATUS = 4'h8;
  localparam logic [3:0] OFF_MASK   = 4'h0;
  localparam logic [3:0] OFF_SUMMARY = 4'h4;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)              phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end

  assign tick_o = (phase_q == LAST);
endmodule

// File: rtl/wdt_channel.sv
module wdt_channel #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          kick_i,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] limit_o,
  output logic          running_o,
  output logic          expired_o,
  output logic          fire_o
);
  logic          kick_live;
  logic          step;

  assign kick_live = kick_i && running_o;
  assign step      = tick_i && running_o && !load_i && !kick_live;
  assign fire_o    = step && (count_o <= CW'(1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      count_o   <= CW'(1);
      limit_o   <= CW'(1);
      running_o <= 1'b0;
      expired_o <= 1'b0;
    end else if (load_i) begin
      limit_o   <= load_val_i;
      count_o   <= load_val_i;
      running_o <= 1'b1;
      expired_o <= 1'b0;
    end else if (kick_live) begin
      count_o <= limit_o;
    end else if (fire_o) begin
      count_o   <= '0;
      running_o <= 1'b0;
      expired_o <= 1'b1;
    end else if (step) begin
      count_o <= count_o - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int LW = $clog2(LEN + 1);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)          left_q <= '0;
    else if (trig_i)      left_q <= LW'(LEN);
    else if (left_q != 0) left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != 0);
endmodule

// File: rtl/wdog_trio.sv
module wdog_trio #(
  parameter int TICK_DIV  = 10_000_000,
  parameter int PULSE_LEN = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [5:0]  addr_i,
  input  logic        rd_en_i,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] rd_data_o,
  output logic        rd_valid_o,
  output logic        irq_o,
  output logic        cpu_rst_o,
  output logic        sys_rst_o
);
  import wdt_pkg::*;
  localparam int CW = DATA_W;

  logic [1:0] win;
  logic [3:0] off;
  assign win = addr_i[5:4];
  assign off = addr_i[3:0];

  logic                        tick;
  logic [NUM_CH-1:0]           ld;
  logic [NUM_CH-1:0]           kick;
  logic [NUM_CH-1:0][CW-1:0]   cnt_a;
  logic [NUM_CH-1:0][CW-1:0]   lim_a;
  logic [NUM_CH-1:0]           run_q;
  logic [NUM_CH-1:0]           exp_q;
  logic [NUM_CH-1:0]           fire;
  logic [NUM_CH-1:0]           act;
  logic [NUM_CH-1:0]           mask_q;
  logic                        irq_q;

  wdt_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ld[g]   = wr_en_i && (win == 2'(g)) && (off == OFF_LIMIT);
    assign kick[g] = rd_en_i && (win == 2'(g)) && (off == OFF_COUNT);

    wdt_channel #(.CW(CW)) u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
      .load_i(ld[g]), .load_val_i(wr_data_i), .kick_i(kick[g]),
      .count_o(cnt_a[g]), .limit_o(lim_a[g]),
      .running_o(run_q[g]), .expired_o(exp_q[g]), .fire_o(fire[g])
    );

    if (g == 0) begin : g_level
      always_ff @(posedge clk_i) begin
        if (!rst_ni) irq_q <= 1'b0;
        else irq_q <= !mask_q[g] && (fire[g] || (exp_q[g] && !ld[g]));
      end
      assign act[g] = irq_q;
    end else begin : g_pulse
      wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .trig_i(fire[g] && !mask_q[g]), .pulse_o(act[g])
      );
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) mask_q <= '0;
    else if (wr_en_i && win == SHARED_WIN && off == OFF_MASK)
      mask_q <= wr_data_i[NUM_CH-1:0];
  end

  logic [15:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (win == SHARED_WIN) begin
      if (off == OFF_MASK)    rd_next = 16'(mask_q);
      if (off == OFF_SUMMARY) rd_next = 16'(exp_q);
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (win == 2'(c)) begin
          if (off == OFF_COUNT)  rd_next = cnt_a[c];
          if (off == OFF_LIMIT)  rd_next = lim_a[c];
          if (off == OFF_STATUS) rd_next = {14'b0, exp_q[c], run_q[c]};
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_next;
    end
  end

  assign irq_o     = act[0];
  assign cpu_rst_o = act[1];
  assign sys_rst_o = act[2];
endmodule

// File: rtl/wdog_trio_chk.sv
module wdog_trio_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_en_i,
  input logic        rd_valid_o,
  input logic        irq_o,
  input logic        cpu_rst_o,
  input logic        sys_rst_o,
  input logic [2:0]  run_q,
  input logic [2:0]  exp_q,
  input logic [2:0]  mask_q,
  input logic [15:0] cnt1,
  input logic [15:0] cnt2
);
  a_r6_expired_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exp_q & run_q) == 3'b000);

  a_r6_ch1_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q[1] |-> cnt1 == 16'd0);

  a_r6_ch2_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q[2] |-> cnt2 == 16'd0);

  a_r7_irq_needs_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> exp_q[0]);

  a_r7_irq_respects_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !$past(mask_q[0]));

  a_r8_pulse_on_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_o) |-> $rose(exp_q[1]));

  a_r9_pulse_on_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $rose(exp_q[2]));

  a_r4_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
endmodule

bind wdog_trio wdog_trio_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .rd_valid_o(rd_valid_o),
  .irq_o(irq_o), .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o),
  .run_q(run_q), .exp_q(exp_q), .mask_q(mask_q),
  .cnt1(cnt_a[1]), .cnt2(cnt_a[2])
);

// File: tb/wdog_trio_tb_top.sv
module wdog_trio_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;
  localparam int PLEN = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rvalid, irq, cpu_rst, sys_rst;

  int checks = 0;
  int errors = 0;
  int ecnt = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  wdog_trio #(.TICK_DIV(DIV), .PULSE_LEN(PLEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_en_i(rd_en),
    .wr_en_i(wr_en), .wr_data_i(wdata), .rd_data_o(rdata),
    .rd_valid_o(rvalid), .irq_o(irq), .cpu_rst_o(cpu_rst), .sys_rst_o(sys_rst)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // monitor: pops scoreboard entries as read results appear
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4: actual unexpected read %0h expected none", rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata, e, t);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] e, input string t);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // wait until the last clock edge was a tick edge
  task automatic align();
    do @(negedge clk); while (ecnt % DIV != 0);
  endtask

  task automatic count_high(input int n, input bit use_sys, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (use_sys ? sys_rst : cpu_rst) hits++;
    end
  endtask

  initial begin
    int hits;
    idle(3);
    check({13'b0, irq, cpu_rst, sys_rst}, 16'h0, "R1 outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd(6'h00, 16'd1, "R1 ch0 count");
    rd(6'h04, 16'd1, "R1 ch0 limit");
    rd(6'h08, 16'd0, "R1 ch0 status");
    rd(6'h14, 16'd1, "R1 ch1 limit");
    rd(6'h20, 16'd1, "R1 ch2 count");
    rd(6'h30, 16'd0, "R1 mask");

    // R2 R3 R4 R5: start ch0, step, keepalive
    align();
    wr(6'h04, 16'd5);
    idle(2*DIV - 1);
    rd(6'h00, 16'd3, "R3 two ticks");
    rd(6'h00, 16'd5, "R4 reload after read");
    rd(6'h04, 16'd5, "R5 limit read");
    rd(6'h04, 16'd5, "R5 limit read again");
    rd(6'h00, 16'd5, "R5 count unchanged");
    rd(6'h08, 16'd1, "R2 running bit");
    wr(6'h30, 16'h0001);
    idle(5*DIV);
    rd(6'h08, 16'd2, "R6 expired status");
    check({15'b0, irq}, 16'd0, "R10 masked irq");
    rd(6'h00, 16'd0, "R6 count zero");
    rd(6'h00, 16'd0, "R6 no reload after expiry");
    rd(6'h34, 16'd1, "R11 summary");
    wr(6'h30, 16'h0000);
    idle(1);
    check({15'b0, irq}, 16'd1, "R7 irq after unmask");
    wr(6'h04, 16'd3);
    check({15'b0, irq}, 16'd0, "R7 irq cleared by limit write");
    rd(6'h08, 16'd1, "R2 restart clears expired");

    // R7 exact timing
    align();
    wr(6'h04, 16'd2);
    idle(2*DIV - 2);
    check({15'b0, irq}, 16'd0, "R7 before expiry");
    idle(1);
    check({15'b0, irq}, 16'd1, "R7 at expiry");

    // R8 ch1 pulse
    align();
    wr(6'h14, 16'd1);
    idle(DIV - 2);
    check({15'b0, cpu_rst}, 16'd0, "R8 before expiry");
    count_high(2*PLEN, 1'b0, hits);
    check(16'(hits), 16'(PLEN), "R8 pulse length");
    check({15'b0, sys_rst}, 16'd0, "R9 no cross trigger");
    rd(6'h18, 16'd2, "R6 ch1 expired");

    // R8 masked: no pulse, still expires
    wr(6'h30, 16'h0002);
    align();
    wr(6'h14, 16'd1);
    count_high(3*DIV, 1'b0, hits);
    check(16'(hits), 16'd0, "R8 masked no pulse");
    rd(6'h18, 16'd2, "R8 masked still expires");

    // R9 ch2 pulse
    wr(6'h30, 16'h0000);
    align();
    wr(6'h24, 16'd2);
    idle(2*DIV - 2);
    check({15'b0, sys_rst}, 16'd0, "R9 before expiry");
    count_high(2*PLEN, 1'b1, hits);
    check(16'(hits), 16'(PLEN), "R9 pulse length");
    rd(6'h34, 16'd7, "R11 all expired");

    // R12 ignored writes
    wr(6'h28, 16'hFFFF);
    wr(6'h20, 16'h1234);
    rd(6'h20, 16'd0, "R12 count write ignored");
    rd(6'h28, 16'd2, "R12 status write ignored");
    idle(3);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R4: actual %0d pending reads expected 0", exp_q.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule